// File: doc/BRIEF.md
# Chip-Select Address Decoder with Two Memory Banks

This block sits between a processor's 16-bit address bus and two byte-wide memory banks. It turns each address into active-low chip selects. A 2 KB bank sits at the bottom of the map. A 4 KB bank follows it directly, and it is built from two adjacent 2 KB decode slots whose selects are combined into one.

A 3-to-8 slot decoder uses address bits 13..11 to pick a 2 KB slot. The slot decoder is enabled only when the bits above it, 15..14, pass the upper-bit check. The parameter `FULL_DECODE` controls that check:
- With `FULL_DECODE = 1`, bits 15..14 must both be zero, so every address line takes part in selection.
- With `FULL_DECODE = 0`, bits 15..14 are ignored. Each bank then also answers at three mirrored copies of its range, 4000h, 8000h and C000h higher.

Behavioural RAMs and a registered read-data path sit behind the selects. A bench can therefore see which bank served each access.

Reads and writes use active-low strobes:
- A write takes effect at the clock edge, only when a bank is selected.
- A read loads the output register at the clock edge. If no bank is selected, the register is loaded with all ones.
- Both strobes active together is reported as a strobe error.

Top module: `csd_chip_select`

## Requirements
- R1: Under full decoding, `cs_n[0]` is low exactly for addresses 0000h–07FFh, and `cs_n` reads 2'b10 there.
- R2: Under full decoding, `cs_n[1]` is low exactly for addresses 0800h–17FFh, and `cs_n` reads 2'b01 there. That range is the union of decode slots 1 and 2.
- R3: An address that no region covers drives `cs_n` to 2'b11. A read there loads FFh into `rdata`, and a write there changes no stored byte.
- R4: At most one bit of `cs_n` is low at any time.
- R5: Each bank is addressed by the offset from its base. The low bank uses address bits 10..0. The high bank uses the address minus 0800h, giving 12 bits. The two banks keep separate storage.
- R6: With `rd_n` low and `wr_n` high, `rdata` takes the selected byte at the next rising clock edge. With `rd_n` high, `rdata` holds its value.
- R7: A byte is stored only when `wr_n` is low, `rd_n` is high and a bank is selected. It is stored at that bank's offset at the rising clock edge.
- R8: When `rd_n` and `wr_n` are both low, `strobe_err` is high. In that case no byte is stored, and `rdata` loads FFh at the next edge.
- R9: With `FULL_DECODE = 0`, address bits 15..14 are ignored. An address and the same address with bits 15..14 changed select the same bank and the same byte.
- R10: While `rst` is high at a rising edge, `rdata` is set to FFh. This is a synchronous, active-high reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address bus |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data; FFh when idle |
| cs_n | output | 2 | Active-low chip selects: bit 0 for the low bank, bit 1 for the high bank |
| strobe_err | output | 1 | High while both strobes are active |

## Verification
The clocked assertions assume that `addr`, `rd_n`, `wr_n` and `wdata` are two-valued and stable around each rising edge. The bench meets this by changing these inputs only on the falling edge.

The one-select property and the range check on the high-bank select assume nothing about the address. They therefore hold for any bus value. The random stimulus covers the whole 64 KB space, the region boundaries, and the mirrored upper quadrants.

The read-path properties assume that a strobe conflict may happen at any time. The stimulus makes such conflicts on purpose, so that the idle-value path and the write suppression are both exercised.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int CSD_ADDR_W    = 16;
    localparam int CSD_DATA_W    = 8;
    localparam int CSD_SLOT_BITS = 11;   // 2 KB decode slot
    localparam int CSD_SEL_BITS  = 3;    // 3-to-8 slot decoder
    localparam int CSD_NUM_BANKS = 2;

    typedef enum logic [1:0] {
        BANK_NONE = 2'd0,
        BANK_LO   = 2'd1,
        BANK_HI   = 2'd2
    } bank_e;

    typedef struct packed {
        logic                  rd;
        logic                  wr;
        logic [CSD_ADDR_W-1:0] addr;
        logic [CSD_DATA_W-1:0] wdata;
    } bus_req_t;

    // Bank 0 spans one slot, bank 1 spans two merged slots
    function automatic int bank_addr_bits(input int idx);
        return (idx == 0) ? CSD_SLOT_BITS : CSD_SLOT_BITS + 1;
    endfunction

endpackage

// File: rtl/csd_slot_decoder.sv
module csd_slot_decoder #(
    parameter int SEL_BITS = csd_pkg::CSD_SEL_BITS,
    localparam int NUM_OUT = 1 << SEL_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [SEL_BITS-1:0] sel,
    output logic [NUM_OUT-1:0]  y_n
);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign y_n[i] = ~(en && (sel == SEL_BITS'(i)));
    end

    // R4: the slot stage never drives two outputs low
    a_r4_slot_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~y_n));

    // R1: a disabled decoder leaves every slot idle
    a_r1_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        !en |-> (y_n == {NUM_OUT{1'b1}}));

endmodule

// File: rtl/csd_bank_select.sv
module csd_bank_select
    import csd_pkg::*;
#(
    parameter int SLOT_BITS = CSD_SLOT_BITS,
    parameter int SEL_BITS  = CSD_SEL_BITS,
    localparam int NUM_SLOTS = 1 << SEL_BITS,
    localparam int LOW_W     = SLOT_BITS + SEL_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LOW_W-1:0]     addr_lo,
    input  logic [NUM_SLOTS-1:0] slot_n,
    output logic [1:0]           cs_n,
    output bank_e                bank,
    output logic [SLOT_BITS:0]   bank_addr
);

    // The high bank's select is low when either of its two slots is low
    assign cs_n[0] = slot_n[0];
    assign cs_n[1] = slot_n[1] & slot_n[2];

    always_comb begin
        bank      = BANK_NONE;
        bank_addr = '0;
        if (!cs_n[0]) begin
            bank      = BANK_LO;
            bank_addr = {1'b0, addr_lo[SLOT_BITS-1:0]};
        end else if (!cs_n[1]) begin
            bank      = BANK_HI;
            // slot 1 is the first half, slot 2 the second
            bank_addr = {slot_n[1], addr_lo[SLOT_BITS-1:0]};
        end
    end

    // R4: at most one chip select is active
    a_r4_one_select: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);

    // R2: the high bank is only selected for slot codes 1 and 2
    a_r2_hi_slots: assert property (@(posedge clk) disable iff (rst)
        !cs_n[1] |-> (addr_lo[LOW_W-1:SLOT_BITS] == SEL_BITS'(1) ||
                      addr_lo[LOW_W-1:SLOT_BITS] == SEL_BITS'(2)));

    // R1: the low bank is only selected for slot code 0
    a_r1_lo_slot: assert property (@(posedge clk) disable iff (rst)
        !cs_n[0] |-> (addr_lo[LOW_W-1:SLOT_BITS] == '0));

endmodule

// File: rtl/csd_ram_bank.sv
module csd_ram_bank #(
    parameter int AW = csd_pkg::CSD_SLOT_BITS,
    parameter int DW = csd_pkg::CSD_DATA_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/csd_chip_select.sv
module csd_chip_select
    import csd_pkg::*;
#(
    parameter int ADDR_W      = CSD_ADDR_W,
    parameter int DATA_W      = CSD_DATA_W,
    parameter int SLOT_BITS   = CSD_SLOT_BITS,
    parameter int SEL_BITS    = CSD_SEL_BITS,
    parameter bit FULL_DECODE = 1'b1,
    localparam int LOW_W      = SLOT_BITS + SEL_BITS,
    localparam int NUM_SLOTS  = 1 << SEL_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        cs_n,
    output logic              strobe_err
);

    bus_req_t            req;
    logic                dec_en;
    logic [NUM_SLOTS-1:0] slot_n;
    bank_e               bank;
    logic [SLOT_BITS:0]  bank_addr;
    logic [DATA_W-1:0]   bank_rd [CSD_NUM_BANKS];
    logic [DATA_W-1:0]   rd_mux;
    logic                rd_ok;
    logic                wr_ok;

    assign req.rd    = ~rd_n;
    assign req.wr    = ~wr_n;
    assign req.addr  = addr;
    assign req.wdata = wdata;

    assign strobe_err = req.rd & req.wr;
    assign rd_ok      = req.rd & ~req.wr;
    assign wr_ok      = req.wr & ~req.rd;

    // Upper-bit qualification picks full or partial decoding
    if (FULL_DECODE) begin : g_full
        assign dec_en = (req.addr[ADDR_W-1:LOW_W] == '0);
    end else begin : g_partial
        assign dec_en = 1'b1;
    end

    csd_slot_decoder #(.SEL_BITS(SEL_BITS)) u_slots (
        .clk (clk),
        .rst (rst),
        .en  (dec_en),
        .sel (req.addr[LOW_W-1:SLOT_BITS]),
        .y_n (slot_n)
    );

    csd_bank_select #(.SLOT_BITS(SLOT_BITS), .SEL_BITS(SEL_BITS)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .addr_lo   (req.addr[LOW_W-1:0]),
        .slot_n    (slot_n),
        .cs_n      (cs_n),
        .bank      (bank),
        .bank_addr (bank_addr)
    );

    for (genvar b = 0; b < CSD_NUM_BANKS; b++) begin : g_bank
        localparam int BAW = (b == 0) ? SLOT_BITS : SLOT_BITS + 1;
        csd_ram_bank #(.AW(BAW), .DW(DATA_W)) u_ram (
            .clk   (clk),
            .we    (wr_ok & ~cs_n[b]),
            .addr  (bank_addr[BAW-1:0]),
            .wdata (req.wdata),
            .rdata (bank_rd[b])
        );
    end

    always_comb begin
        unique case (bank)
            BANK_LO: rd_mux = bank_rd[0];
            BANK_HI: rd_mux = bank_rd[1];
            default: rd_mux = {DATA_W{1'b1}};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= {DATA_W{1'b1}};
        end else if (req.rd) begin
            rdata <= rd_ok ? rd_mux : {DATA_W{1'b1}};
        end
    end

    // R10: reset drives the idle value
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (rdata == {DATA_W{1'b1}}));

    // R3: an unselected read returns the idle value
    a_r3_idle_read: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && wr_n && (cs_n == 2'b11)) |=> (rdata == {DATA_W{1'b1}}));

    // R8: a strobe conflict returns the idle value
    a_r8_conflict_idle: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !wr_n) |=> (rdata == {DATA_W{1'b1}}));

    // R6: no read strobe, no change of read data
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        rd_n |=> $stable(rdata));

endmodule

// File: tb/csd_chip_select_tb.sv
module csd_chip_select_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        rd_n, wr_n;
    logic [7:0]  wdata;
    logic [7:0]  rdata_f, rdata_p;
    logic [1:0]  cs_f, cs_p;
    logic        err_f, err_p;

    int nvec  = 0;
    int nfail = 0;

    logic [7:0] sh_lo_f [2048];
    logic [7:0] sh_hi_f [4096];
    logic [7:0] sh_lo_p [2048];
    logic [7:0] sh_hi_p [4096];
    logic [7:0] exp_rd_f, exp_rd_p;

    always #(CLK_PERIOD/2) clk = ~clk;

    csd_chip_select #(.FULL_DECODE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .wdata(wdata), .rdata(rdata_f), .cs_n(cs_f), .strobe_err(err_f));

    csd_chip_select #(.FULL_DECODE(1'b0)) u_dut_part (
        .clk(clk), .rst(rst), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .wdata(wdata), .rdata(rdata_p), .cs_n(cs_p), .strobe_err(err_p));

    // 0 none, 1 low bank, 2 high bank
    function automatic int exp_bank(input logic [15:0] a, input bit full);
        logic [15:0] m;
        if (full && a[15:14] != 2'b00) return 0;
        m = a & 16'h3FFF;
        if (m < 16'h0800) return 1;
        if (m < 16'h1800) return 2;
        return 0;
    endfunction

    function automatic int exp_off(input logic [15:0] a, input int bk);
        logic [15:0] m;
        m = a & 16'h3FFF;
        if (bk == 1) return int'(m);
        return int'(m - 16'h0800);
    endfunction

    function automatic logic [1:0] exp_cs(input int bk);
        return (bk == 1) ? 2'b10 : (bk == 2) ? 2'b01 : 2'b11;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, expv);
        end
    endtask

    function automatic string cs_tag(input int bk, input bit full);
        if (!full) return "R9";
        return (bk == 1) ? "R1" : (bk == 2) ? "R2" : "R3";
    endfunction

    // Entered at a falling edge; returns at the next falling edge
    task automatic apply(input logic [15:0] a, input bit rd, input bit wr,
                         input logic [7:0] d);
        int bf, bp, of, op;
        addr = a; rd_n = ~rd; wr_n = ~wr; wdata = d;
        #1;
        bf = exp_bank(a, 1'b1);
        bp = exp_bank(a, 1'b0);
        chk(cs_f == exp_cs(bf), cs_tag(bf, 1'b1), {14'd0, cs_f}, {14'd0, exp_cs(bf)});
        chk(cs_p == exp_cs(bp), cs_tag(bp, 1'b0), {14'd0, cs_p}, {14'd0, exp_cs(bp)});
        chk($countones(~cs_f) <= 1, "R4", {14'd0, cs_f}, 16'd3);
        chk(err_f == (rd && wr), "R8", {15'd0, err_f}, {15'd0, rd && wr});
        of = (bf != 0) ? exp_off(a, bf) : 0;
        op = (bp != 0) ? exp_off(a, bp) : 0;
        if (rd && wr) begin
            exp_rd_f = 8'hFF; exp_rd_p = 8'hFF;
        end else if (rd) begin
            exp_rd_f = (bf == 1) ? sh_lo_f[of] : (bf == 2) ? sh_hi_f[of] : 8'hFF;
            exp_rd_p = (bp == 1) ? sh_lo_p[op] : (bp == 2) ? sh_hi_p[op] : 8'hFF;
        end
        @(posedge clk);
        #1;
        if (wr && !rd) begin
            if (bf == 1) sh_lo_f[of] = d; else if (bf == 2) sh_hi_f[of] = d;
            if (bp == 1) sh_lo_p[op] = d; else if (bp == 2) sh_hi_p[op] = d;
        end
        @(negedge clk);
        chk(rdata_f === exp_rd_f, rd ? (rd && wr ? "R8" : (bf == 0 ? "R3" : "R6")) : "R6",
            {8'd0, rdata_f}, {8'd0, exp_rd_f});
        chk(rdata_p === exp_rd_p, rd ? "R9" : "R6", {8'd0, rdata_p}, {8'd0, exp_rd_p});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h0000_5EED));
        rst = 1'b1; addr = '0; rd_n = 1'b1; wr_n = 1'b1; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: idle value after reset
        chk(rdata_f == 8'hFF, "R10", {8'd0, rdata_f}, 16'h00FF);
        chk(rdata_p == 8'hFF, "R10", {8'd0, rdata_p}, 16'h00FF);
        exp_rd_f = 8'hFF; exp_rd_p = 8'hFF;

        // R7/R5: fill both banks through the bus at their offsets
        for (int i = 0; i < 16'h1800; i++)
            apply(16'(i), 1'b0, 1'b1, 8'(i * 7 + (i >> 8)));

        // R1/R2: region edges, R5 offsets
        apply(16'h0000, 1'b1, 1'b0, 8'h00);
        apply(16'h07FF, 1'b1, 1'b0, 8'h00);
        apply(16'h0800, 1'b1, 1'b0, 8'h00);
        apply(16'h17FF, 1'b1, 1'b0, 8'h00);
        // R3: just past the map, top of space
        apply(16'h1800, 1'b1, 1'b0, 8'h00);
        apply(16'hFFFF, 1'b1, 1'b0, 8'h00);
        apply(16'h1800, 1'b0, 1'b1, 8'hA5);
        // R9: mirrors in the partial decoder
        apply(16'h4000, 1'b1, 1'b0, 8'h00);
        apply(16'hC7FF, 1'b1, 1'b0, 8'h00);
        apply(16'h8800, 1'b0, 1'b1, 8'h3C);
        apply(16'h0800, 1'b1, 1'b0, 8'h00);
        // R8: conflict, then the stored byte is unchanged
        apply(16'h0010, 1'b1, 1'b1, 8'h5A);
        apply(16'h0010, 1'b1, 1'b0, 8'h00);
        // R6: hold while idle
        apply(16'h0020, 1'b0, 1'b0, 8'h00);

        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a;
            int op, kind;
            a    = 16'($urandom);
            kind = $urandom % 3;
            if (kind == 1) a = a & 16'h1FFF;
            else if (kind == 2) a = (a & 16'h1FFF) | 16'($urandom % 4) << 14;
            op = $urandom % 8;
            apply(a, op < 3 || op == 5, op == 3 || op == 4 || op == 5, 8'($urandom));
        end

        // R10: reset mid-run after a read left non-idle data
        apply(16'h0001, 1'b1, 1'b0, 8'h00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(rdata_f == 8'hFF, "R10", {8'd0, rdata_f}, 16'h00FF);
        chk(rdata_p == 8'hFF, "R10", {8'd0, rdata_p}, 16'h00FF);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule